// File: doc/BRIEF.md
# Successive-Approximation A/D Conversion Controller

This block is the digital half of a successive-approximation converter. Software sets it up and reads it through a byte-wide register port with three addresses. The block puts a 10-bit trial code on an external comparison-voltage DAC and a 4-bit input select on an analog multiplexer. It samples a single comparator bit that is high when the analog input is at or above the trial level. From those samples it runs a most-significant-bit-first binary search and stores the answer.

A conversion starts when a 0 is written to the completion bit of the control register. The input select and the conversion width are captured at that moment. Wide mode gives a 10-bit answer. Narrow mode gives an 8-bit answer whose trial levels sit half a step below the plain binary levels. When the last bit is decided, the result registers update together, the completion bit sets, and a one-cycle interrupt request pulse is produced. In wide mode, result register 1 returns either the upper eight bits or the lower eight bits of the answer. Which one it returns depends on whether result register 2 was read just before.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Register address 0 is the control register. Writing it with bit 3 = 0 starts a conversion. Bit 3 then reads 0 while the conversion runs and reads 1 once it has finished. Writing it with bit 3 = 1 starts nothing and leaves bit 3 unchanged.
- R2: Control bits 2:0 are the input index within a group, bit 4 is the group, bit 5 always reads 0, and bits 7:6 are two output-enable flags that read back and drive `outEn[1:0]`. At a start, `chanSel` is loaded with {bit 4, bits 2:0} of the starting write.
- R3: Address 2 bit 7 is the width select (0 = 10-bit, 1 = 8-bit). It is writable and reads back in bit 7 of address 2.
- R4: The search is MSB-first and takes two clock cycles per bit. The completion bit reads 1 exactly 20 clock edges after the starting write's edge in 10-bit mode, and exactly 16 edges after it in 8-bit mode. A 10-bit result is the largest code n with trial level n no greater than the input.
- R5: In 8-bit mode the DAC code for trial n is 4n−2 for n ≥ 1 and 0 for n = 0. The 8-bit result is returned in result register 1 (address 1).
- R6: Address 2 reads as {width bit, five zeros, result bits 9:8}. Result bits 9:8 are 0 after an 8-bit conversion.
- R7: After a 10-bit conversion, address 1 returns result bits 9:2. It returns result bits 7:0 instead when the most recent result read before it was a read of address 2. A read of address 1 and a conversion start both clear that condition.
- R8: While a conversion runs, both result registers keep the previous completed result unchanged.
- R9: `irq` is high for exactly one cycle, in the cycle in which the completion bit first reads 1.
- R10: A start write during a running conversion abandons it and begins again from the MSB. The full conversion time then counts from the new write.
- R11: After reset, the control register reads 0x08, both result registers read 0, `outEn` is 0, `chanSel` is 0 and `irq` is low.
- R12: Control writes with bit 3 = 1 and width-select writes made during a conversion do not change `chanSel`, the width in use, or the result of that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (drives the read-order side effects) |
| addr | input | 2 | Register address: 0 control, 1 result 1, 2 result 2 |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| cmpHigh | input | 1 | Comparator: input at or above the trial level |
| trialCode | output | 10 | Code for the comparison-voltage DAC |
| chanSel | output | 4 | Analog multiplexer select, captured at start |
| outEn | output | 2 | Output-enable flags from the control register |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
The bench drives an ideal comparator. It converts the input extremes 0 and 1023 in both widths, and narrow inputs of 1 and 2 that sit on either side of the first half-step level. Mapping narrow trials without the half-step offset would return 0 for an input of 2 instead of 1. The bench then walks the read-order sequences: address 1 alone, address 2 then address 1, and address 1 a second time. A flag that is never cleared would keep returning the low byte. It also reads the result registers in the middle of a conversion to catch results that are exposed early. It aborts a conversion partway through and changes the setup during a run. A design that re-read the live channel or width, or kept counting from the first start, would report the wrong select, the wrong result or the wrong timing.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RES1 = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RES2 = 2'd2;
  localparam int BIT_DONE = 3;
  localparam int BIT_GROUP = 4;
  localparam int BIT_WIDTH = 7;

  typedef struct packed {
    logic start;
    logic decide;
    logic mode8;
  } sarStrobe_t;
endpackage

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_adc_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strobe,
  input  logic             cmpHigh,
  output logic [RES_W-1:0] trialCode,
  output logic [RES_W-1:0] resultQ,
  output logic             resMode8Q,
  output logic             convMode8Q,
  output logic             lastBit
);
  localparam int SHIFT = RES_W - NARROW_W;
  localparam int PTR_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] WIDE_MSB = RES_W'(1) << (RES_W - 1);
  localparam logic [RES_W-1:0] NARROW_MSB = RES_W'(1) << (NARROW_W - 1);
  localparam logic [PTR_W-1:0] WIDE_TOP = PTR_W'(RES_W - 1);
  localparam logic [PTR_W-1:0] NARROW_TOP = PTR_W'(NARROW_W - 1);

  logic [RES_W-1:0] codeQ;
  logic [RES_W-1:0] nextCode;
  logic [PTR_W-1:0] ptrQ;
  logic [RES_W-1:0] narrowLevel;

  assign lastBit = (ptrQ == '0);

  always_comb begin
    nextCode = codeQ;
    if (!cmpHigh) nextCode[ptrQ] = 1'b0;
    if (ptrQ != '0) nextCode[ptrQ - PTR_W'(1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ      <= '0;
      ptrQ       <= '0;
      resultQ    <= '0;
      resMode8Q  <= 1'b0;
      convMode8Q <= 1'b0;
    end else if (strobe.start) begin
      convMode8Q <= strobe.mode8;
      codeQ      <= strobe.mode8 ? NARROW_MSB : WIDE_MSB;
      ptrQ       <= strobe.mode8 ? NARROW_TOP : WIDE_TOP;
    end else if (strobe.decide) begin
      codeQ <= nextCode;
      if (ptrQ != '0) begin
        ptrQ <= ptrQ - PTR_W'(1);
      end else begin
        resultQ   <= nextCode;
        resMode8Q <= convMode8Q;
      end
    end
  end

  generate
    if (SHIFT > 0) begin : g_halfStep
      localparam logic [RES_W-1:0] HALF_STEP = RES_W'(1) << (SHIFT - 1);
      logic [RES_W-1:0] scaled;
      assign scaled = RES_W'(codeQ[NARROW_W-1:0]) << SHIFT;
      assign narrowLevel = (codeQ[NARROW_W-1:0] == '0) ? '0 : scaled - HALF_STEP;
    end else begin : g_plain
      assign narrowLevel = codeQ;
    end
  endgenerate

  assign trialCode = convMode8Q ? narrowLevel : codeQ;
endmodule

// File: rtl/sar_control.sv
module sar_control
  import sar_adc_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int DATA_W = 8,
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [RES_W-1:0]  resultQ,
  input  logic              resMode8Q,
  input  logic              lastBit,
  output sarStrobe_t        strobe,
  output logic [CHAN_W-1:0] chanSel,
  output logic [1:0]        outEn,
  output logic              irq,
  output logic              busyQ,
  output logic              doneQ
);
  localparam int LOW_W = CHAN_W - 1;
  localparam int HI_W = RES_W - DATA_W;
  localparam int PAD_W = DATA_W - 1 - HI_W;

  logic [LOW_W-1:0] chanLoQ;
  logic             groupQ;
  logic [1:0]       enableQ;
  logic             modeQ;
  logic             phaseQ;
  logic             lowFirstQ;
  logic             irqQ;
  logic [CHAN_W-1:0] chanSelQ;

  logic startW, decideW, finishW, ctrlWrite;

  assign ctrlWrite = wrEn && (addr == ADDR_CTRL);
  assign startW    = ctrlWrite && !wrData[BIT_DONE];
  assign decideW   = busyQ && phaseQ && !startW;
  assign finishW   = decideW && lastBit;

  assign strobe = '{start: startW, decide: decideW, mode8: modeQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanLoQ   <= '0;
      groupQ    <= 1'b0;
      enableQ   <= '0;
      modeQ     <= 1'b0;
      doneQ     <= 1'b1;
      busyQ     <= 1'b0;
      phaseQ    <= 1'b0;
      lowFirstQ <= 1'b0;
      irqQ      <= 1'b0;
      chanSelQ  <= '0;
    end else begin
      irqQ <= finishW;
      if (ctrlWrite) begin
        chanLoQ <= wrData[LOW_W-1:0];
        groupQ  <= wrData[BIT_GROUP];
        enableQ <= wrData[DATA_W-1 -: 2];
      end
      if (wrEn && (addr == ADDR_RES2)) modeQ <= wrData[BIT_WIDTH];
      if (startW) begin
        chanSelQ <= {wrData[BIT_GROUP], wrData[LOW_W-1:0]};
        busyQ    <= 1'b1;
        doneQ    <= 1'b0;
        phaseQ   <= 1'b0;
      end else if (finishW) begin
        busyQ  <= 1'b0;
        doneQ  <= 1'b1;
        phaseQ <= 1'b0;
      end else if (busyQ) begin
        phaseQ <= ~phaseQ;
      end
      if (startW) lowFirstQ <= 1'b0;
      else if (rdEn && (addr == ADDR_RES2)) lowFirstQ <= 1'b1;
      else if (rdEn && (addr == ADDR_RES1)) lowFirstQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL: rdData = {enableQ, 1'b0, groupQ, doneQ, chanLoQ};
      ADDR_RES1: rdData = (resMode8Q || lowFirstQ) ? resultQ[DATA_W-1:0]
                                                   : resultQ[RES_W-1 -: DATA_W];
      ADDR_RES2: rdData = {modeQ, {PAD_W{1'b0}}, resultQ[RES_W-1:DATA_W]};
      default:   rdData = '0;
    endcase
  end

  assign chanSel = chanSelQ;
  assign outEn   = enableQ;
  assign irq     = irqQ;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int NARROW_W = 8,
  parameter int DATA_W = 8,
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              cmpHigh,
  output logic [RES_W-1:0]  trialCode,
  output logic [CHAN_W-1:0] chanSel,
  output logic [1:0]        outEn,
  output logic              irq
);
  sarStrobe_t       strobe;
  logic [RES_W-1:0] resultQ;
  logic             resMode8Q;
  logic             convMode8Q;
  logic             lastBit;
  logic             busyQ;
  logic             doneQ;

  sar_control #(.RES_W(RES_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .resultQ(resultQ), .resMode8Q(resMode8Q),
    .lastBit(lastBit), .strobe(strobe), .chanSel(chanSel), .outEn(outEn),
    .irq(irq), .busyQ(busyQ), .doneQ(doneQ)
  );

  sar_datapath #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .resultQ(resultQ), .resMode8Q(resMode8Q),
    .convMode8Q(convMode8Q), .lastBit(lastBit)
  );
endmodule

// File: rtl/sar_adc_checker.sv
module sar_adc_checker #(
  parameter int RES_W = 10,
  parameter int DATA_W = 8,
  parameter int CHAN_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wrData,
  input logic              busyQ,
  input logic              doneQ,
  input logic              irq,
  input logic [RES_W-1:0]  resultQ,
  input logic [CHAN_W-1:0] chanSel,
  input logic [RES_W-1:0]  trialCode,
  input logic              convMode8Q
);
  logic startCond;
  assign startCond = wrEn && (addr == 2'd0) && !wrData[3];

  AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rstN)
    startCond |=> (busyQ && !doneQ)); // R1
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ == !busyQ); // R1
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R9
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (doneQ && $past(busyQ))); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultQ) |-> irq); // R8
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !startCond) |=> $stable(chanSel)); // R12
  AST_NARROW_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    convMode8Q |-> ((trialCode == '0) || (trialCode[1:0] == 2'b10))); // R5
endmodule

bind sar_adc_ctrl sar_adc_checker #(.RES_W(RES_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .busyQ(busyQ), .doneQ(doneQ), .irq(irq), .resultQ(resultQ),
  .chanSel(chanSel), .trialCode(trialCode), .convMode8Q(convMode8Q)
);

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       cmpHigh;
  logic [9:0] trialCode;
  logic [3:0] chanSel;
  logic [1:0] outEn;
  logic       irq;
  int vin = 0;
  int nChecks = 0;
  int nFails = 0;

  sar_adc_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cmpHigh(cmpHigh), .trialCode(trialCode),
    .chanSel(chanSel), .outEn(outEn), .irq(irq)
  );

  always #4 clk = ~clk;
  always_comb cmpHigh = (int'(trialCode) <= vin);

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; addr = 2'd0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0; addr = 2'd0;
  endtask

  task automatic peekCtrl(output logic [7:0] d);
    addr = 2'd0;
    #1 d = rdData;
  endtask

  // Called on the negedge right after a start edge; expCycles < 0 skips the timing check.
  task automatic waitDone(input int expCycles, input string req);
    logic [7:0] c;
    int cyc = 0;
    peekCtrl(c);
    while (!c[3] && cyc < 200) begin
      @(negedge clk);
      cyc++;
      peekCtrl(c);
    end
    if (expCycles >= 0) check(req, cyc, expCycles);
    check("R9 irq at completion", int'(irq), 1);
    @(negedge clk);
    check("R9 irq single cycle", int'(irq), 0);
  endtask

  task automatic runConv(input logic [7:0] ctrl, input int v, input int expCycles);
    logic [7:0] c;
    vin = v;
    busWrite(2'd0, ctrl & 8'hF7);
    peekCtrl(c);
    check("R1 bit3 low while running", int'(c[3]), 0);
    waitDone(expCycles, "R4 conversion time");
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R11 irq", int'(irq), 0);
    check("R11 outEn", int'(outEn), 0);
    check("R11 chanSel", int'(chanSel), 0);
    busRead(2'd0, d); check("R11 control", int'(d), 8'h08);
    busRead(2'd1, d); check("R11 result1", int'(d), 0);
    busRead(2'd2, d); check("R11 result2", int'(d), 0);
  endtask

  task automatic testCtrlFields();
    logic [7:0] d;
    busWrite(2'd0, 8'hFD);
    busRead(2'd0, d);
    check("R2 control readback bit5 zero", int'(d), 8'hDD);
    check("R2 outEn", int'(outEn), 2'b11);
    check("R1 bit3=1 write no start chanSel", int'(chanSel), 0);
    repeat (3) @(negedge clk);
    check("R1 no irq without start", int'(irq), 0);
    busWrite(2'd0, 8'h08);
    check("R2 outEn cleared", int'(outEn), 0);
  endtask

  task automatic testWide();
    int vals[4] = '{0, 1023, 517, 682};
    logic [7:0] d;
    foreach (vals[i]) begin
      int v = vals[i];
      logic [3:0] ch = 4'(i * 5 + 3);
      runConv({3'b000, ch[3], 1'b0, ch[2:0]}, v, 20);
      check("R2 chanSel latched", int'(chanSel), int'(ch));
      busRead(2'd1, d); check("R7 result1 high byte", int'(d), (v >> 2) & 255);
      busRead(2'd2, d); check("R6 result2", int'(d), (v >> 8) & 3);
      busRead(2'd1, d); check("R7 result1 low after result2", int'(d), v & 255);
      busRead(2'd1, d); check("R7 flag cleared by result1 read", int'(d), (v >> 2) & 255);
    end
  endtask

  task automatic testNarrow();
    int vals[5] = '{1, 2, 513, 1023, 0};
    logic [7:0] d;
    busWrite(2'd2, 8'h80);
    busRead(2'd2, d);
    check("R3 width bit readback", int'(d) & 8'h80, 8'h80);
    foreach (vals[i]) begin
      int v = vals[i];
      int e = (v + 2) / 4;
      if (e > 255) e = 255;
      runConv(8'h01, v, 16);
      busRead(2'd1, d); check("R5 narrow result", int'(d), e);
      busRead(2'd2, d); check("R6 result2 narrow", int'(d), 8'h80);
      busRead(2'd1, d); check("R5 narrow result after result2", int'(d), e);
    end
    busWrite(2'd2, 8'h00);
  endtask

  task automatic testHold();
    logic [7:0] d;
    runConv(8'h00, 682, 20);
    vin = 100;
    busWrite(2'd0, 8'h00);
    repeat (4) @(negedge clk);
    busRead(2'd2, d); check("R8 result2 held", int'(d), 2);
    busRead(2'd1, d); check("R8 result1 held", int'(d), 682 & 255);
    busRead(2'd1, d); check("R8 result1 held high", int'(d), 682 >> 2);
    waitDone(-1, "R8");
    busRead(2'd1, d); check("R8 new result", int'(d), 100 >> 2);
  endtask

  task automatic testAbort();
    logic [7:0] d;
    vin = 300;
    busWrite(2'd0, 8'h03);
    repeat (7) @(negedge clk);
    vin = 700;
    busWrite(2'd0, 8'h11);
    waitDone(20, "R10 restart timing");
    check("R10 chanSel of restart", int'(chanSel), 9);
    busRead(2'd1, d); check("R10 result high", int'(d), 700 >> 2);
    busRead(2'd2, d); check("R10 result2", int'(d), 2);
    busRead(2'd1, d); check("R10 result low", int'(d), 700 & 255);
  endtask

  task automatic testLatch();
    logic [7:0] d;
    busRead(2'd2, d);
    vin = 411;
    busWrite(2'd0, 8'h02);
    repeat (2) @(negedge clk);
    busWrite(2'd0, 8'h1E);
    busWrite(2'd2, 8'h80);
    check("R12 chanSel unchanged", int'(chanSel), 2);
    waitDone(-1, "R12");
    busRead(2'd0, d); check("R12 control shows new setup", int'(d), 8'h1E);
    busRead(2'd1, d); check("R7 start cleared flag / R12 wide result", int'(d), 411 >> 2);
    busRead(2'd2, d); check("R12 result2", int'(d), 8'h81);
    busWrite(2'd2, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCtrlFields();
    testWide();
    testNarrow();
    testHold();
    testAbort();
    testLatch();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule